// File: doc/BRIEF.md
# Touch Conversion Scheduler

This block decides when a touchscreen or sensor conversion may begin, times each conversion, and records which result channels hold unread data. A host loads a control word: enable, the function code that names what to convert, and a precision code. On every clock edge the scheduler checks the pen-pressure input and the data already waiting, and starts the next conversion when the rules for that function allow it. The analog conversion is stood in for by a fixed number of conversion ticks. When the ticks run out, a channel mask chosen by the function is ORed into the data-available (DAV) mask.

Reading a channel is signalled by a one-cycle acknowledge on that channel's bit, which clears the bit. Some single-channel functions turn the block off once any result is waiting, so each enable gives one conversion. An active-low interrupt pin follows a selectable source: pressure, pending data, or pressure with nothing pending. The block also truncates an external 16-bit sample to the latched precision and presents a 16-bit status word.

Top module: `tsc_conv_sched`

## Requirements
- R1: After a synchronous reset the block is disabled and not busy. The DAV mask, result, latched function and latched precision are 0, and `irq_n_o` is 1.
- R2: A conversion starts only when the block is enabled and not busy. Functions 1–5 also need `pen_i` high. Functions 6–12 start whatever the pressure. Functions 0, 13, 14 and 15 never start.
- R3: On the edge that starts a conversion, `busy_o` rises and `cur_func_o`/`cur_prec_o` take the stored next function and precision. No conversion starts on an edge that loads a control write.
- R4: While busy, each edge with `tick_i` high uses up one of CONV_TICKS ticks. The edge that uses up the last one clears `busy_o`.
- R5: On that completing edge the function's mask is ORed into `dav_o`, where bit 10=X, 9=Y, 8=Z1, 7=Z2, 6=BAT1, 5=BAT2, 4=AUX1, 3=AUX2, 2=TEMP1, 1=TEMP2, 0=DAC. The masks are: 1→0x600, 2→0x780, 3→0x400, 4→0x200, 5→0x180, 6→0x040, 7→0x030, 8 and 9→0x010, 10→0x004, 11→0x070, 12→0x002, all others→0.
- R6: A high `rd_ack_i[k]` clears `dav_o[k]` on the next edge. If a completion sets the same bit on that edge, the set wins.
- R7: Functions 3–8, 10 and 12 are single-shot: once any DAV bit is set, the enable is cleared (for 3–5 only while `pen_i` is high). A conversion already running still completes.
- R8: A control write with enable 0 clears the enable and cancels a running conversion, so that conversion adds no DAV bits.
- R9: `irq_n_o` is registered and is the inverse of a level taken from the previous cycle's state. With `pin_sel_i`=0 the level is `pen_i`. With 1 it is (DAV≠0). With 2 or 3 it is `pen_i` AND (DAV=0). The level is forced to 0 while disabled.
- R10: Each edge, `result_o` takes `sample_i` shifted right by 16−bits, where bits is set by the latched precision: 0→12, 1→8, 2→10, 3→12.
- R11: `status_o` = {`pin_sel_i`[1:0], not-enabled, 1'b0, DAV≠0, `dav_o`[10:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pen_i | input | 1 | Pen pressure |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_en_i | input | 1 | Enable value for the write |
| ctl_func_i | input | 4 | Next function code for the write |
| ctl_prec_i | input | 2 | Next precision code for the write |
| pin_sel_i | input | 2 | Interrupt source select |
| rd_ack_i | input | 11 | Per-channel read acknowledge |
| tick_i | input | 1 | Conversion-time tick |
| sample_i | input | SAMPLE_W | Raw sample from the converter |
| dav_o | output | 11 | Data-available mask |
| busy_o | output | 1 | Conversion in progress |
| cur_func_o | output | 4 | Function latched at start |
| cur_prec_o | output | 2 | Precision latched at start |
| irq_n_o | output | 1 | Active-low interrupt |
| result_o | output | SAMPLE_W | Truncated sample |
| status_o | output | 16 | Status word |

## Verification
The embedded properties check on every cycle that:
- the tick counter stays in range;
- a start latches the stored function and never one of the idle codes;
- a single-shot function never starts with data pending;
- a disabling write leaves the block idle;
- the interrupt stays high while disabled;
- an acknowledged bit is clear unless it was set again on the same edge.

Only the bench's reference model can show the exact DAV masks and the timing of completions against irregular ticks. The same holds for the repeating scans while the pen stays down, the cleared enable in single-shot modes, the choice of interrupt source, and the truncation for each precision.

// File: rtl/tsc_sched_pkg.sv
package tsc_sched_pkg;
  localparam int DAV_W  = 11;
  localparam int FUNC_W = 4;
  localparam int PREC_W = 2;

  function automatic logic [DAV_W-1:0] dav_mask(input logic [FUNC_W-1:0] f);
    case (f)
      4'd1:        dav_mask = 11'h600;
      4'd2:        dav_mask = 11'h780;
      4'd3:        dav_mask = 11'h400;
      4'd4:        dav_mask = 11'h200;
      4'd5:        dav_mask = 11'h180;
      4'd6:        dav_mask = 11'h040;
      4'd7:        dav_mask = 11'h030;
      4'd8, 4'd9:  dav_mask = 11'h010;
      4'd10:       dav_mask = 11'h004;
      4'd11:       dav_mask = 11'h070;
      4'd12:       dav_mask = 11'h002;
      default:     dav_mask = '0;
    endcase
  endfunction

  function automatic logic needs_pen(input logic [FUNC_W-1:0] f);
    needs_pen = (f >= 4'd1) && (f <= 4'd5);
  endfunction

  function automatic logic one_shot(input logic [FUNC_W-1:0] f);
    one_shot = ((f >= 4'd3) && (f <= 4'd8)) || (f == 4'd10) || (f == 4'd12);
  endfunction

  function automatic logic runnable(input logic [FUNC_W-1:0] f);
    runnable = (f >= 4'd1) && (f <= 4'd12);
  endfunction

  function automatic int prec_bits(input logic [PREC_W-1:0] p);
    case (p)
      2'd1:    prec_bits = 8;
      2'd2:    prec_bits = 10;
      default: prec_bits = 12;
    endcase
  endfunction
endpackage

// File: rtl/tsc_start_rule.sv
module tsc_start_rule
  import tsc_sched_pkg::*;
(
  input  logic              en,
  input  logic              busy,
  input  logic              hold,
  input  logic              pen,
  input  logic              dav_any,
  input  logic [FUNC_W-1:0] func,
  output logic              start,
  output logic              kill
);
  logic pen_ok;

  always_comb begin
    pen_ok = !needs_pen(func) || pen;
    kill   = en && one_shot(func) && pen_ok && dav_any;
    start  = en && !busy && !hold && runnable(func) && pen_ok && !kill;
  end
endmodule

// File: rtl/tsc_conv_timer.sv
module tsc_conv_timer #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cancel,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(TICKS + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(TICKS);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign done = busy_q && tick && (cnt_q == ONE) && !cancel;
  assign busy = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (cancel || done) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q && tick) begin
      cnt_q  <= cnt_q - ONE;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LOAD && (busy_q || cnt_q == '0)); // R4
endmodule

// File: rtl/tsc_dav_track.sv
module tsc_dav_track
  import tsc_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [FUNC_W-1:0] func,
  input  logic [DAV_W-1:0]  ack,
  output logic [DAV_W-1:0]  dav
);
  logic [DAV_W-1:0] set_v;
  logic [DAV_W-1:0] dav_q;

  assign set_v = done ? dav_mask(func) : '0;
  assign dav   = dav_q;

  for (genvar i = 0; i < DAV_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) dav_q[i] <= 1'b0;
      else     dav_q[i] <= (dav_q[i] && !ack[i]) || set_v[i];
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      ($past(ack[i]) && !$past(set_v[i])) |-> !dav_q[i]); // R6
  end
endmodule

// File: rtl/tsc_conv_sched.sv
module tsc_conv_sched
  import tsc_sched_pkg::*;
#(
  parameter int CONV_TICKS = 4,
  parameter int SAMPLE_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pen_i,
  input  logic                ctl_wr_i,
  input  logic                ctl_en_i,
  input  logic [3:0]          ctl_func_i,
  input  logic [1:0]          ctl_prec_i,
  input  logic [1:0]          pin_sel_i,
  input  logic [10:0]         rd_ack_i,
  input  logic                tick_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [10:0]         dav_o,
  output logic                busy_o,
  output logic [3:0]          cur_func_o,
  output logic [1:0]          cur_prec_o,
  output logic                irq_n_o,
  output logic [SAMPLE_W-1:0] result_o,
  output logic [15:0]         status_o
);
  logic              en_q;
  logic [FUNC_W-1:0] nfunc_q, func_q;
  logic [PREC_W-1:0] nprec_q, prec_q;
  logic              irq_n_q;
  logic [SAMPLE_W-1:0] res_q;
  logic              start, kill, cancel, done, busy, dav_any, irq_lvl;
  logic [DAV_W-1:0]  dav;

  assign dav_any = |dav;
  assign cancel  = ctl_wr_i && !ctl_en_i;

  tsc_start_rule u_rule (
    .en(en_q), .busy(busy), .hold(ctl_wr_i), .pen(pen_i),
    .dav_any(dav_any), .func(nfunc_q), .start(start), .kill(kill)
  );

  tsc_conv_timer #(.TICKS(CONV_TICKS)) u_timer (
    .clk(clk), .rst(rst), .start(start), .cancel(cancel),
    .tick(tick_i), .busy(busy), .done(done)
  );

  tsc_dav_track u_dav (
    .clk(clk), .rst(rst), .done(done), .func(func_q),
    .ack(rd_ack_i), .dav(dav)
  );

  always_comb begin
    case (pin_sel_i)
      2'd0:    irq_lvl = pen_i;
      2'd1:    irq_lvl = dav_any;
      default: irq_lvl = pen_i && !dav_any;
    endcase
    if (!en_q) irq_lvl = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      nfunc_q <= '0;
      nprec_q <= '0;
      func_q  <= '0;
      prec_q  <= '0;
      irq_n_q <= 1'b1;
      res_q   <= '0;
    end else begin
      if (ctl_wr_i) begin
        en_q    <= ctl_en_i;
        nfunc_q <= ctl_func_i;
        nprec_q <= ctl_prec_i;
      end else if (kill) begin
        en_q    <= 1'b0;
      end
      if (start) begin
        func_q <= nfunc_q;
        prec_q <= nprec_q;
      end
      irq_n_q <= !irq_lvl;
      res_q   <= sample_i >> (SAMPLE_W - prec_bits(prec_q));
    end
  end

  assign dav_o      = dav;
  assign busy_o     = busy;
  assign cur_func_o = func_q;
  assign cur_prec_o = prec_q;
  assign irq_n_o    = irq_n_q;
  assign result_o   = res_q;
  assign status_o   = {pin_sel_i, !en_q, 1'b0, dav_any, dav};

  AST_START_LATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (cur_func_o == $past(nfunc_q) && cur_prec_o == $past(nprec_q))); // R3
  AST_NO_IDLE_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (cur_func_o != 4'd0 && cur_func_o <= 4'd12)); // R2
  AST_ONESHOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy_o) && one_shot(cur_func_o)) |-> ($past(dav_o) == '0)); // R7
  AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(ctl_wr_i && !ctl_en_i) |-> !busy_o); // R8
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(en_q) |-> irq_n_o); // R9
endmodule

// File: tb/sim_tsc_conv_sched.sv
module sim_tsc_conv_sched;
  localparam int NT = 4;

  logic clk = 0, rst = 1;
  logic pen_i = 0, ctl_wr_i = 0, ctl_en_i = 0, tick_i = 0;
  logic [3:0]  ctl_func_i = 0;
  logic [1:0]  ctl_prec_i = 0, pin_sel_i = 2;
  logic [10:0] rd_ack_i = 0;
  logic [15:0] sample_i = 0;
  logic [10:0] dav_o;
  logic busy_o, irq_n_o;
  logic [3:0]  cur_func_o;
  logic [1:0]  cur_prec_o;
  logic [15:0] result_o, status_o;

  always #4 clk = ~clk;

  tsc_conv_sched #(.CONV_TICKS(NT), .SAMPLE_W(16)) u0 (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done_run = 0;

  // behavioural reference state
  int m_en, m_nf, m_np, m_busy, m_left, m_f, m_p, m_dav, m_irqn, m_res;

  function automatic int mmask(int f);
    case (f)
      1: return 'h600;  2: return 'h780;  3: return 'h400;  4: return 'h200;
      5: return 'h180;  6: return 'h040;  7: return 'h030;  8: return 'h010;
      9: return 'h010; 10: return 'h004; 11: return 'h070; 12: return 'h002;
      default: return 0;
    endcase
  endfunction

  function automatic int mbits(int p);
    return (p == 1) ? 8 : (p == 2) ? 10 : 12;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_nf = 0; m_np = 0; m_busy = 0; m_left = 0;
      m_f = 0; m_p = 0; m_dav = 0; m_irqn = 1; m_res = 0;
    end else begin
      int fin, cut, shot, go, pok, lvl;
      cut  = ctl_wr_i && !ctl_en_i && m_busy;
      fin  = m_busy && tick_i && (m_left == 1) && !cut;
      pok  = (m_nf >= 1 && m_nf <= 5) ? pen_i : 1;
      shot = m_en && ((m_nf >= 3 && m_nf <= 8) || m_nf == 10 || m_nf == 12)
             && pok && (m_dav != 0);
      go   = m_en && !m_busy && !ctl_wr_i && (m_nf >= 1 && m_nf <= 12) && pok && !shot;
      case (pin_sel_i)
        0: lvl = pen_i;
        1: lvl = (m_dav != 0);
        default: lvl = pen_i && (m_dav == 0);
      endcase
      if (!m_en) lvl = 0;
      m_irqn = !lvl;
      m_res  = int'(sample_i) >> (16 - mbits(m_p));
      m_dav  = (m_dav & ~int'(rd_ack_i)) | (fin ? mmask(m_f) : 0);
      if (go) begin
        m_busy = 1; m_left = NT; m_f = m_nf; m_p = m_np;
      end else if (cut || fin) begin
        m_busy = 0; m_left = 0;
      end else if (m_busy && tick_i) m_left = m_left - 1;
      if (ctl_wr_i) begin
        m_en = ctl_en_i; m_nf = ctl_func_i; m_np = ctl_prec_i;
      end else if (shot) m_en = 0;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    tick_i <= (cyc % 5) != 4;
    if (!rst && !done_run) begin
      check("R5/R6 dav", dav_o, m_dav);
      check("R4 busy", busy_o, m_busy);
      check("R3 func", cur_func_o, m_f);
      check("R3 prec", cur_prec_o, m_p);
      check("R9 irq", irq_n_o, m_irqn);
      check("R10 result", result_o, m_res);
      check("R11 status", status_o,
            (int'(pin_sel_i) << 14) | ((!m_en) << 13) | ((m_dav != 0) << 11) | m_dav);
    end
    if (cyc > 100000 && !done_run) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl(bit en, int f, int p);
    @(negedge clk);
    ctl_wr_i = 1; ctl_en_i = en; ctl_func_i = 4'(f); ctl_prec_i = 2'(p);
    @(negedge clk);
    ctl_wr_i = 0;
  endtask

  task automatic ack_all();
    @(negedge clk); rd_ack_i = '1;
    @(negedge clk); rd_ack_i = '0;
  endtask

  initial begin
    wait_n(3);
    rst = 0;
    wait_n(1);
    // R1 reset state
    check("R1 busy", busy_o, 0);
    check("R1 dav", dav_o, 0);
    check("R1 irq", irq_n_o, 1);
    check("R1 status", status_o, 'hA000);

    // R2: scan mode waits for pen
    ctl(1, 1, 0);
    wait_n(12);
    check("R2 no start without pen", busy_o, 0);
    pen_i = 1;
    wait_n(40);
    check("R2 scan result", dav_o & 11'h600, 'h600);

    // R7: single-shot X
    ctl(0, 1, 0); wait_n(10); ack_all();
    ctl(1, 3, 2);
    wait_n(40);
    check("R7 disabled after shot", status_o[13], 1);
    check("R7 X dav", dav_o, 'h400);

    // R8: cancel mid conversion
    ack_all();
    ctl(1, 6, 0);
    @(negedge clk);
    check("R8 running", busy_o, 1);
    ctl_wr_i = 1; ctl_en_i = 0; ctl_func_i = 6;
    @(negedge clk); ctl_wr_i = 0;
    wait_n(20);
    check("R8 idle", busy_o, 0);
    check("R8 no dav", dav_o, 0);

    // R2: idle and driver codes never start
    ctl(1, 0, 0); wait_n(10);
    check("R2 code 0", busy_o, 0);
    ctl(1, 13, 0); wait_n(10);
    check("R2 code 13", busy_o, 0);

    // R9: pressure source, then forced off
    pin_sel_i = 0; pen_i = 1; wait_n(3);
    check("R9 pen source", irq_n_o, 0);
    ctl(0, 0, 0); wait_n(3);
    check("R9 disabled", irq_n_o, 1);

    // R10: precision truncation, pen-free aux scan
    pen_i = 0; sample_i = 16'hABCD;
    for (int p = 0; p < 4; p++) begin
      ctl(1, 9, p);
      wait_n(15);
      check("R10 cut", result_o, 16'hABCD >> (16 - mbits(p)));
    end
    ctl(0, 0, 0);

    // mixed traffic against the model
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      pen_i     = ($urandom % 6) != 0 ? pen_i : !pen_i;
      pin_sel_i = ($urandom % 50) == 0 ? 2'($urandom) : pin_sel_i;
      sample_i  = 16'($urandom);
      rd_ack_i  = ($urandom % 4) == 0 ? 11'($urandom) : '0;
      ctl_wr_i  = ($urandom % 12) == 0;
      ctl_en_i  = ($urandom % 5) != 0;
      ctl_func_i = 4'($urandom);
      ctl_prec_i = 2'($urandom);
    end
    @(negedge clk);
    ctl_wr_i = 0; rd_ack_i = 0;
    wait_n(2);
    done_run = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule